// File: doc/BRIEF.md
# Byte Shift and Rotate Unit with Status Flags

This block performs the one-bit shift and rotate operations of an 8-bit accumulator-style processor. An operand byte, an incoming carry and a 2-bit operation code go in; the shifted byte and the next negative, zero and carry flags come out in the same cycle. The flags are also captured in registers when the enable is high. The registered carry can then be fed back as the carry-in for the next byte, so a sequencer can shift an integer several bytes wide one byte at a time.

The right shift of a wide value starts at its top byte with a logical shift right. Each lower byte then gets a rotate right that takes the carry left behind by the byte above it. At the end, the registered carry holds the bit that was dropped, which is the remainder of the halving.

A separate decoder maps each rotate-right opcode to an addressing-mode code, an instruction length in bytes and a cycle count, for use by a surrounding sequencer. It flags any other opcode as invalid.

Top module: `shrot_unit`

## Requirements
- R1: With `op` = 2'b11 (rotate right), `res` = {`cin`, `opnd[7:1]`} and `c_o` = `opnd[0]`.
- R2: With `op` = 2'b01 (logical shift right), `res` = {1'b0, `opnd[7:1]`} and `c_o` = `opnd[0]`, whatever the value of `cin`.
- R3: With `op` = 2'b00 (shift left), `res` = {`opnd[6:0]`, 1'b0} and `c_o` = `opnd[7]`, whatever the value of `cin`.
- R4: With `op` = 2'b10 (rotate left), `res` = {`opnd[6:0]`, `cin`} and `c_o` = `opnd[7]`.
- R5: `n_o` equals `res[7]`, and `z_o` is 1 exactly when `res` is 8'h00. Both are valid in the same cycle as the inputs.
- R6: On a rising clock edge with `en` high, `flag_n_q`, `flag_z_q` and `flag_c_q` take the values of `n_o`, `z_o` and `c_o`. With `en` low, all three keep their values.
- R7: While `rst_n` is low, all three registered flags are 0.
- R8: The decoder gives `mode`, `len` and `cyc` for the rotate-right opcodes as follows: 8'h6A gives mode 1 (accumulator), 1 byte, 2 cycles; 8'h66 gives mode 4 (zero page), 2 bytes, 5 cycles; 8'h76 gives mode 5 (zero page indexed), 2 bytes, 6 cycles; 8'h6E gives mode 2 (absolute), 3 bytes, 6 cycles; 8'h7E gives mode 3 (absolute indexed), 3 bytes, 7 cycles. For these opcodes `bad_op` is 0.
- R9: Any other opcode gives `bad_op` = 1 and `mode`, `len` and `cyc` all 0.
- R10: Start with a logical shift right on the top byte, then rotate right each lower byte in turn with `cin` = `flag_c_q` and `en` high at every step. The bytes produced then form the input value shifted right by one, and `flag_c_q` ends up holding the bit that was shifted out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Load enable for the flag registers |
| op | input | 2 | Operation: 00 shift left, 01 shift right, 10 rotate left, 11 rotate right |
| cin | input | 1 | Incoming carry |
| opnd | input | 8 | Operand byte |
| res | output | 8 | Result byte (combinational) |
| n_o | output | 1 | Next negative flag (combinational) |
| z_o | output | 1 | Next zero flag (combinational) |
| c_o | output | 1 | Next carry flag (combinational) |
| flag_n_q | output | 1 | Registered negative flag |
| flag_z_q | output | 1 | Registered zero flag |
| flag_c_q | output | 1 | Registered carry flag |
| opcode | input | 8 | Opcode to decode |
| mode | output | 3 | Addressing-mode code, 0 when invalid |
| len | output | 2 | Instruction length in bytes, 0 when invalid |
| cyc | output | 3 | Cycle count, 0 when invalid |
| bad_op | output | 1 | Opcode is not a rotate-right opcode |

## Verification
The assertions assume that `op`, `cin`, `opnd` and `en` are known, 2-state values at every clock edge after reset. They also assume that `en` being high during reset is of no concern, because the load check only looks at cycles where reset was already released. The bench drives every input to a defined value before it releases reset. It changes the inputs only on falling edges, so each rising edge sees steady values. It holds `en` low until a scenario asks for a flag load.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

    typedef enum logic [1:0] {
        OP_SHL = 2'b00,
        OP_SHR = 2'b01,
        OP_ROL = 2'b10,
        OP_ROR = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        AM_NONE = 3'd0,
        AM_ACC  = 3'd1,
        AM_ABS  = 3'd2,
        AM_ABSX = 3'd3,
        AM_ZP   = 3'd4,
        AM_ZPX  = 3'd5
    } amode_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
    } flags_t;

endpackage

// File: rtl/shrot_core.sv
module shrot_core
    import shrot_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [1:0]   op,
    input  logic         cin,
    input  logic [W-1:0] opnd,
    output logic [W-1:0] res,
    output flags_t       flg
);
    localparam int MSB = W - 1;

    logic         fill;
    logic         out_bit;
    logic [W-1:0] shifted;

    always_comb begin
        // Bit 0 of op selects direction, bit 1 selects whether carry feeds in
        fill    = op[1] ? cin : 1'b0;
        if (op[0]) begin
            shifted = {fill, opnd[MSB:1]};
            out_bit = opnd[0];
        end else begin
            shifted = {opnd[MSB-1:0], fill};
            out_bit = opnd[MSB];
        end
        res   = shifted;
        flg.n = shifted[MSB];
        flg.z = (shifted == '0);
        flg.c = out_bit;
    end

endmodule

// File: rtl/shrot_decode.sv
module shrot_decode
    import shrot_pkg::*;
(
    input  logic [7:0] opcode,
    output logic [2:0] mode,
    output logic [1:0] len,
    output logic [2:0] cyc,
    output logic       bad_op
);
    amode_e m;

    always_comb begin
        m      = AM_NONE;
        len    = 2'd0;
        cyc    = 3'd0;
        bad_op = 1'b0;
        unique case (opcode)
            8'h6A: begin m = AM_ACC;  len = 2'd1; cyc = 3'd2; end
            8'h66: begin m = AM_ZP;   len = 2'd2; cyc = 3'd5; end
            8'h76: begin m = AM_ZPX;  len = 2'd2; cyc = 3'd6; end
            8'h6E: begin m = AM_ABS;  len = 2'd3; cyc = 3'd6; end
            8'h7E: begin m = AM_ABSX; len = 2'd3; cyc = 3'd7; end
            default: bad_op = 1'b1;
        endcase
        mode = m;
    end

endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
    import shrot_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [1:0] op,
    input  logic       cin,
    input  logic [7:0] opnd,
    output logic [7:0] res,
    output logic       n_o,
    output logic       z_o,
    output logic       c_o,
    output logic       flag_n_q,
    output logic       flag_z_q,
    output logic       flag_c_q,
    input  logic [7:0] opcode,
    output logic [2:0] mode,
    output logic [1:0] len,
    output logic [2:0] cyc,
    output logic       bad_op
);
    flags_t nxt;
    flags_t flags_d;
    flags_t flags_q;

    shrot_core #(.W(8)) u_core (
        .op   (op),
        .cin  (cin),
        .opnd (opnd),
        .res  (res),
        .flg  (nxt)
    );

    shrot_decode u_dec (
        .opcode (opcode),
        .mode   (mode),
        .len    (len),
        .cyc    (cyc),
        .bad_op (bad_op)
    );

    always_comb begin
        flags_d = en ? nxt : flags_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign n_o      = nxt.n;
    assign z_o      = nxt.z;
    assign c_o      = nxt.c;
    assign flag_n_q = flags_q.n;
    assign flag_z_q = flags_q.z;
    assign flag_c_q = flags_q.c;

    p_ror_msb_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 2'b11) |-> (res[7] == cin && c_o == opnd[0]));
    p_shr_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 2'b01) |-> (!res[7] && !n_o && c_o == opnd[0]));
    p_shl_lsb_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 2'b00) |-> (!res[0] && c_o == opnd[7]));
    p_rol_lsb_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 2'b10) |-> (res[0] == cin && c_o == opnd[7]));
    p_zero_not_neg_r5: assert property (@(posedge clk) disable iff (!rst_n)
        z_o |-> !n_o);
    p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && en) |=> (flag_n_q == $past(n_o) && flag_z_q == $past(z_o)
                           && flag_c_q == $past(c_o)));
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !en) |=> $stable({flag_n_q, flag_z_q, flag_c_q}));
    p_dec_cyc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !bad_op |-> (cyc > {1'b0, len} && mode != 3'd0));
    p_bad_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bad_op |-> (len == 2'd0 && cyc == 3'd0 && mode == 3'd0));

endmodule

// File: tb/tb_shrot_unit.sv
module tb_shrot_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [1:0] op = 2'b00;
    logic       cin = 1'b0;
    logic [7:0] opnd = 8'h00;
    logic [7:0] res;
    logic       n_o, z_o, c_o;
    logic       flag_n_q, flag_z_q, flag_c_q;
    logic [7:0] opcode = 8'h00;
    logic [2:0] mode;
    logic [1:0] len;
    logic [2:0] cyc;
    logic       bad_op;

    int total = 0;
    int bad = 0;

    shrot_unit dut (
        .clk(clk), .rst_n(rst_n), .en(en), .op(op), .cin(cin), .opnd(opnd),
        .res(res), .n_o(n_o), .z_o(z_o), .c_o(c_o),
        .flag_n_q(flag_n_q), .flag_z_q(flag_z_q), .flag_c_q(flag_c_q),
        .opcode(opcode), .mode(mode), .len(len), .cyc(cyc), .bad_op(bad_op)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference: returns {carry, result}
    function automatic logic [8:0] model(input logic [1:0] o, input logic [7:0] a, input logic ci);
        case (o)
            2'b00: return {a[7], a[6:0], 1'b0};
            2'b01: return {a[0], 1'b0, a[7:1]};
            2'b10: return {a[7], a[6:0], ci};
            default: return {a[0], ci, a[7:1]};
        endcase
    endfunction

    task automatic t_reset();
        @(negedge clk);
        chk("R7 reset flags", {29'd0, flag_n_q, flag_z_q, flag_c_q}, 32'd0);
    endtask

    task automatic t_sweep();
        string tag[4] = '{"R3", "R2", "R4", "R1"};
        for (int o = 0; o < 4; o++) begin
            for (int a = 0; a < 256; a++) begin
                for (int c = 0; c < 2; c++) begin
                    logic [8:0] e;
                    @(negedge clk);
                    op = 2'(o); opnd = 8'(a); cin = 1'(c);
                    #1;
                    e = model(2'(o), 8'(a), 1'(c));
                    chk(tag[o], {23'd0, c_o, res}, {23'd0, e});
                    chk("R5 flags", {30'd0, n_o, z_o}, {30'd0, e[7], e[7:0] == 8'h00});
                end
            end
        end
    endtask

    task automatic t_regs();
        // load carry=1, neg=1 via rotate right of 0x01 with cin=1 -> 0x80
        @(negedge clk);
        op = 2'b11; opnd = 8'h01; cin = 1'b1; en = 1'b1;
        @(posedge clk); #1;
        chk("R6 load", {29'd0, flag_n_q, flag_z_q, flag_c_q}, {29'd0, 3'b101});
        @(negedge clk);
        en = 1'b0; op = 2'b01; opnd = 8'h00; cin = 1'b0;
        @(posedge clk); #1;
        chk("R6 hold", {29'd0, flag_n_q, flag_z_q, flag_c_q}, {29'd0, 3'b101});
        @(negedge clk);
        en = 1'b1;
        @(posedge clk); #1;
        chk("R6 load zero", {29'd0, flag_n_q, flag_z_q, flag_c_q}, {29'd0, 3'b010});
        @(negedge clk);
        en = 1'b0;
    endtask

    task automatic t_decode();
        logic [7:0] ops [5] = '{8'h6A, 8'h66, 8'h76, 8'h6E, 8'h7E};
        logic [2:0] em  [5] = '{3'd1, 3'd4, 3'd5, 3'd2, 3'd3};
        logic [1:0] el  [5] = '{2'd1, 2'd2, 2'd2, 2'd3, 2'd3};
        logic [2:0] ec  [5] = '{3'd2, 3'd5, 3'd6, 3'd6, 3'd7};
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            opcode = ops[i];
            #1;
            chk("R8 decode", {24'd0, bad_op, mode, len, cyc},
                {24'd0, 1'b0, em[i], el[i], ec[i]});
        end
        for (int v = 0; v < 256; v++) begin
            logic valid;
            @(negedge clk);
            opcode = 8'(v);
            #1;
            valid = (v == 'h6A || v == 'h66 || v == 'h76 || v == 'h6E || v == 'h7E);
            if (!valid)
                chk("R9 invalid", {24'd0, bad_op, mode, len, cyc}, {24'd0, 9'b1_000_00_000});
        end
    endtask

    task automatic t_chain(input logic [31:0] val, input logic pre_c);
        logic [31:0] got;
        // Preload registered carry to pre_c (shift left of 0x80 or 0x00)
        @(negedge clk);
        op = 2'b00; opnd = pre_c ? 8'h80 : 8'h00; en = 1'b1;
        @(posedge clk);
        for (int b = 3; b >= 0; b--) begin
            @(negedge clk);
            op   = (b == 3) ? 2'b01 : 2'b11;
            cin  = flag_c_q;
            opnd = val[b*8 +: 8];
            #1;
            got[b*8 +: 8] = res;
            @(posedge clk);
        end
        @(negedge clk);
        en = 1'b0;
        chk("R10 chain value", got, val >> 1);
        chk("R10 chain carry", {31'd0, flag_c_q}, {31'd0, val[0]});
    endtask

    initial begin
        #1000000;
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        t_reset();
        rst_n = 1'b1;
        t_sweep();
        t_regs();
        t_decode();
        t_chain(32'hDEAD_BEEF, 1'b1);
        t_chain(32'h8000_0002, 1'b1);
        t_chain(32'h0000_0001, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R7 reset clears", {29'd0, flag_n_q, flag_z_q, flag_c_q}, 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule